// File: doc/BRIEF.md
# Synthesizer Configuration Register

This block holds the working configuration of a fractional-N frequency synthesizer: a 6-bit integer and a 12-bit fractional feedback divider value, a 2-bit divider-mode code, two 3-bit output divider codes, and a 2-bit test-select code. The configuration can arrive in one of two ways. A three-wire serial port has a serial clock, a data line and a load strobe. Bits enter a shift register on each rising serial clock, and a rising load strobe copies the whole shift register into the working configuration in one step. Alternatively, a set of parallel pins drives the divider and mode fields. The `par_mode` pin selects between the two paths.

The serial clock, serial data and load strobe are brought into the `clk` domain through a synchronizer chain of `SYNC_STAGES` flops, and their edges are detected there. A test output can stream the shift register contents out for readback, so that software can verify what it shifted in. A master reset input empties the shift register and leaves the working configuration untouched. The block has no data stream with flow control. Every pin is a plain level, so there is no valid/ready handshake and no back-pressure.

The serial word is 28 bits long and is sent most significant bit first. From the most significant end, its fields are: test select [27:26], mode [25:24], output divider A [23:21], output divider B [20:18], integer part [17:12], and fractional part [11:0].

Top module: `synth_cfg_regs`

## Requirements
- R1: In serial mode (`par_mode`=0), each rising edge of `s_clk` shifts `s_data` into bit 0 of the shift register and moves every other bit one place toward bit 27. Falling edges do not shift. In parallel mode the shift register does not shift.
- R2: In serial mode, a rising edge of `s_load` copies the 28-bit shift register into the working configuration, using the field positions given above. Without such an edge the working configuration stays unchanged.
- R3: In serial mode, `test_out` follows the test-select field as follows. Code 01 drives `test_out` with shift register bit 27. Code 00 drives it low. The reserved codes 10 and 11 also drive it low.
- R4: In parallel mode, `test_out` is low whatever the test-select code and the shift register contents.
- R5: A high `mr` clears the shift register and leaves every working configuration field unchanged.
- R6: A mode code of 11 sets `frac_en`=1 and `ds_err`=0. A code of 00 sets both to 0. The invalid codes 01 and 10 set `ds_err`=1 and `frac_en`=0, so they act as integer mode.
- R7: In parallel mode, while `s_load` is low, the working divider and mode fields follow the parallel pins. While `s_load` is high they hold the values captured when it rose, and a rise of `s_load` does not copy the shift register. The test-select field keeps its value throughout parallel mode.
- R8: After `rst_n` is asserted, every configuration output, `frac_en`, `ds_err` and `test_out` are 0.
- R9: When a rising `s_clk` and a rising `s_load` reach the block in the same cycle, the working configuration receives the shift register contents from before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset to default configuration |
| par_mode | input | 1 | 1 selects the parallel source, 0 selects the serial source |
| mr | input | 1 | Master reset; clears the shift register only |
| s_clk | input | 1 | Serial clock; data is taken on its rising edge |
| s_data | input | 1 | Serial data, most significant bit first |
| s_load | input | 1 | Serial load strobe / parallel capture strobe |
| p_mint | input | 6 | Parallel integer part |
| p_mfrac | input | 12 | Parallel fractional part |
| p_ds | input | 2 | Parallel mode code |
| p_odiv_a | input | 3 | Parallel output divider A code |
| p_odiv_b | input | 3 | Parallel output divider B code |
| mint | output | 6 | Working integer part |
| mfrac | output | 12 | Working fractional part |
| odiv_a | output | 3 | Working output divider A code |
| odiv_b | output | 3 | Working output divider B code |
| frac_en | output | 1 | Fractional mode active |
| ds_err | output | 1 | Invalid mode code held |
| test_out | output | 1 | Test output (shift register readback or low) |

## Verification
The serial shift and the serial load can take effect in the same cycle. The bench provokes this by raising `s_clk` and `s_load` on the same clock edge after a full word has been shifted in. It then judges the result in two ways. The working fields must match the word as it stood before the shift. The readback on `test_out` must already show the shifted register, which places the word's bit 26 in the output position.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int INT_W  = 6;
  localparam int FRAC_W = 12;
  localparam int ODIV_W = 3;
  localparam int MODE_W = 2;
  localparam int TSEL_W = 2;
  localparam int CFG_W  = TSEL_W + MODE_W + 2 * ODIV_W + INT_W + FRAC_W;

  typedef enum logic [TSEL_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_RSV2  = 2'b10,
    TSEL_RSV3  = 2'b11
  } tsel_e;

  localparam logic [MODE_W-1:0] MODE_INT  = 2'b00;
  localparam logic [MODE_W-1:0] MODE_FRAC = 2'b11;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic [MODE_W-1:0] ds;
    logic [ODIV_W-1:0] odiv_a;
    logic [ODIV_W-1:0] odiv_b;
    logic [INT_W-1:0]  mint;
    logic [FRAC_W-1:0] mfrac;
  } cfg_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_st
      logic [W-1:0] r;
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= '0;
          else        r <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= '0;
          else        r <= g_st[i-1].r;
      end
    end
  endgenerate

  assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_mode,
  input  logic             mr,
  input  logic             sclk_s,
  input  logic             sdata_s,
  output logic [CFG_W-1:0] sr
);
  logic sclk_d;
  logic sclk_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;

  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      sr <= '0;
    else if (mr)                     sr <= '0;
    else if (ser_mode && sclk_rise)  sr <= {sr[CFG_W-2:0], sdata_s};

  // R1: a serial rising edge moves the register by one place
  assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && sclk_rise && !mr) |=>
      (sr[0] == $past(sdata_s)) && (sr[CFG_W-1:1] == $past(sr[CFG_W-2:0])));

  // R1: no shift without an edge or outside serial mode
  assert_no_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ser_mode && sclk_rise) && !mr) |=> $stable(sr));

  // R5: master reset empties the shift register
  assert_mr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> (sr == '0));
endmodule

// File: rtl/synth_cfg_store.sv
module synth_cfg_store
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              load_s,
  input  logic [CFG_W-1:0]  sr,
  input  logic [INT_W-1:0]  p_mint,
  input  logic [FRAC_W-1:0] p_mfrac,
  input  logic [MODE_W-1:0] p_ds,
  input  logic [ODIV_W-1:0] p_odiv_a,
  input  logic [ODIV_W-1:0] p_odiv_b,
  output cfg_t              cfg
);
  logic load_d;
  logic load_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) load_d <= 1'b0;
    else        load_d <= load_s;

  assign load_rise = load_s & ~load_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (par_mode) begin
      if (!load_s) begin
        cfg.ds     <= p_ds;
        cfg.odiv_a <= p_odiv_a;
        cfg.odiv_b <= p_odiv_b;
        cfg.mint   <= p_mint;
        cfg.mfrac  <= p_mfrac;
      end
    end else if (load_rise) begin
      cfg <= cfg_t'(sr);
    end
  end

  // R2, R9: a serial load takes the register as it stood in that cycle
  assert_load_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && load_rise) |=> (cfg == cfg_t'($past(sr))));

  // R2: without a load edge the configuration holds
  assert_hold_serial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !load_rise) |=> $stable(cfg));

  // R7: parallel mode with strobe high holds
  assert_hold_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && load_s) |=> $stable(cfg));

  // R7: transparent parallel path, test select untouched
  assert_transparent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !load_s) |=>
      (cfg.mint == $past(p_mint)) && (cfg.mfrac == $past(p_mfrac)) &&
      (cfg.ds == $past(p_ds)) && $stable(cfg.tsel));
endmodule

// File: rtl/synth_cfg_view.sv
module synth_cfg_view
  import synth_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic par_mode,
  input  cfg_t cfg,
  input  logic sr_msb,
  output logic test_out,
  output logic frac_en,
  output logic ds_err
);
  always_comb begin
    test_out = 1'b0;
    if (!par_mode) begin
      unique case (tsel_e'(cfg.tsel))
        TSEL_SHIFT: test_out = sr_msb;
        TSEL_LOW,
        TSEL_RSV2,
        TSEL_RSV3:  test_out = 1'b0;
        default:    test_out = 1'b0;
      endcase
    end
  end

  always_comb begin
    frac_en = (cfg.ds == MODE_FRAC);
    ds_err  = (cfg.ds != MODE_FRAC) && (cfg.ds != MODE_INT);
  end

  // R4: the test pin stays low in parallel mode
  assert_par_test_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> !test_out);

  // R3: reserved and low codes never drive the pin high
  assert_rsvd_test_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.tsel != TSEL_SHIFT) |-> !test_out);

  // R6: error and fractional flags are exclusive
  assert_ds_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({frac_en, ds_err}) <= 1);
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              mr,
  input  logic              s_clk,
  input  logic              s_data,
  input  logic              s_load,
  input  logic [INT_W-1:0]  p_mint,
  input  logic [FRAC_W-1:0] p_mfrac,
  input  logic [MODE_W-1:0] p_ds,
  input  logic [ODIV_W-1:0] p_odiv_a,
  input  logic [ODIV_W-1:0] p_odiv_b,
  output logic [INT_W-1:0]  mint,
  output logic [FRAC_W-1:0] mfrac,
  output logic [ODIV_W-1:0] odiv_a,
  output logic [ODIV_W-1:0] odiv_b,
  output logic              frac_en,
  output logic              ds_err,
  output logic              test_out
);
  localparam int NSER = 3;

  logic [NSER-1:0]  ser_s;
  logic [CFG_W-1:0] sr;
  cfg_t             cfg;

  synth_cfg_sync #(.W(NSER), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({s_load, s_data, s_clk}),
    .q     (ser_s)
  );

  synth_cfg_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_mode (!par_mode),
    .mr       (mr),
    .sclk_s   (ser_s[0]),
    .sdata_s  (ser_s[1]),
    .sr       (sr)
  );

  synth_cfg_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .load_s   (ser_s[2]),
    .sr       (sr),
    .p_mint   (p_mint),
    .p_mfrac  (p_mfrac),
    .p_ds     (p_ds),
    .p_odiv_a (p_odiv_a),
    .p_odiv_b (p_odiv_b),
    .cfg      (cfg)
  );

  synth_cfg_view u_view (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .cfg      (cfg),
    .sr_msb   (sr[CFG_W-1]),
    .test_out (test_out),
    .frac_en  (frac_en),
    .ds_err   (ds_err)
  );

  assign mint   = cfg.mint;
  assign mfrac  = cfg.mfrac;
  assign odiv_a = cfg.odiv_a;
  assign odiv_b = cfg.odiv_b;

  // R5: master reset alone never alters the working configuration
  assert_mr_keeps_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mr && !par_mode && !(ser_s[2] && !$past(ser_s[2]))) |=>
      ($stable(mint) && $stable(mfrac) && $stable(odiv_a) && $stable(odiv_b)));
endmodule

// File: tb/synth_cfg_regs_bench.sv
module synth_cfg_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 28;
  localparam int NVEC = 6;
  // word layout: {tsel[1:0], ds[1:0], odiv_a[2:0], odiv_b[2:0], mint[5:0], mfrac[11:0]}
  localparam logic [W-1:0] VEC [NVEC] = '{
    {2'b01, 2'b11, 3'd5, 3'd2, 6'h2A, 12'hABC},
    {2'b00, 2'b00, 3'd7, 3'd0, 6'h3F, 12'hFFF},
    {2'b01, 2'b01, 3'd1, 3'd6, 6'h0C, 12'h001},
    {2'b10, 2'b10, 3'd3, 3'd3, 6'h28, 12'h800},
    {2'b11, 2'b11, 3'd0, 3'd7, 6'h01, 12'h555},
    {2'b01, 2'b00, 3'd4, 3'd1, 6'h36, 12'h000}
  };

  logic clk = 1'b0, rst_n = 1'b0, par_mode = 1'b0, mr = 1'b0;
  logic s_clk = 1'b0, s_data = 1'b0, s_load = 1'b0;
  logic [5:0] p_mint = '0;
  logic [11:0] p_mfrac = '0;
  logic [1:0] p_ds = '0;
  logic [2:0] p_odiv_a = '0, p_odiv_b = '0;
  logic [5:0] mint;
  logic [11:0] mfrac;
  logic [2:0] odiv_a, odiv_b;
  logic frac_en, ds_err, test_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  synth_cfg_regs u_synth_cfg_regs (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .mr(mr),
    .s_clk(s_clk), .s_data(s_data), .s_load(s_load),
    .p_mint(p_mint), .p_mfrac(p_mfrac), .p_ds(p_ds),
    .p_odiv_a(p_odiv_a), .p_odiv_b(p_odiv_b),
    .mint(mint), .mfrac(mfrac), .odiv_a(odiv_a), .odiv_b(odiv_b),
    .frac_en(frac_en), .ds_err(ds_err), .test_out(test_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic sbit(input logic b);
    s_data = b; s_clk = 1'b0; tick(4);
    s_clk = 1'b1; tick(4);
  endtask

  task automatic sword(input logic [W-1:0] w);
    for (int i = W-1; i >= 0; i--) sbit(w[i]);
    s_clk = 1'b0; tick(4);
  endtask

  task automatic pulse_load();
    s_load = 1'b1; tick(4);
    s_load = 1'b0; tick(4);
  endtask

  task automatic chk_cfg(input string req, input logic [W-1:0] w);
    chk(req, {26'd0, mint}, {26'd0, w[17:12]});
    chk(req, {20'd0, mfrac}, {20'd0, w[11:0]});
    chk(req, {29'd0, odiv_a}, {29'd0, w[23:21]});
    chk(req, {29'd0, odiv_b}, {29'd0, w[20:18]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, w9;
    tick(3);
    // R8: reset state
    chk("R8 mint", {26'd0, mint}, 32'd0);
    chk("R8 mfrac", {20'd0, mfrac}, 32'd0);
    chk("R8 flags", {29'd0, frac_en, ds_err, test_out}, 32'd0);
    rst_n = 1'b1; tick(2);

    // R2, R3, R6: table of serial words
    for (int v = 0; v < NVEC; v++) begin
      sword(VEC[v]);
      pulse_load();
      chk_cfg("R2 load", VEC[v]);
      chk("R6 frac_en", {31'd0, frac_en}, {31'd0, VEC[v][25:24] == 2'b11});
      chk("R6 ds_err", {31'd0, ds_err},
          {31'd0, (VEC[v][25:24] == 2'b01) || (VEC[v][25:24] == 2'b10)});
      sbit(1'b0); sbit(1'b0); s_clk = 1'b0; tick(4);
      chk("R3 test", {31'd0, test_out},
          {31'd0, (VEC[v][27:26] == 2'b01) ? VEC[v][25] : 1'b0});
      chk_cfg("R2 hold", VEC[v]);
    end

    // R1: full readback through the test pin
    sword(VEC[0]); pulse_load();
    x = 28'h9A5C3E1;
    sword(x);
    for (int j = 0; j < W; j++) begin
      chk("R1 readback", {31'd0, test_out}, {31'd0, x[W-1-j]});
      sbit(1'b0); s_clk = 1'b0; tick(4);
    end

    // R5: master reset clears register, keeps configuration
    sword(x);
    mr = 1'b1; tick(4); mr = 1'b0; tick(2);
    chk("R5 test low", {31'd0, test_out}, 32'd0);
    chk_cfg("R5 cfg kept", VEC[0]);
    pulse_load();
    chk("R5 cleared", {26'd0, mint}, 32'd0);

    // R4, R7: parallel source
    sword(VEC[0]); pulse_load();
    sbit(1'b0); sbit(1'b0); s_clk = 1'b0; tick(4);
    chk("R3 test high", {31'd0, test_out}, 32'd1);
    par_mode = 1'b1; p_mint = 6'h11; p_mfrac = 12'h123; p_ds = 2'b10;
    p_odiv_a = 3'd6; p_odiv_b = 3'd1; tick(4);
    chk("R4 test low", {31'd0, test_out}, 32'd0);
    chk("R7 transparent", {26'd0, mint}, 32'h11);
    chk("R7 ds err", {30'd0, ds_err, frac_en}, 32'd2);
    p_mint = 6'h22; p_mfrac = 12'h456; p_ds = 2'b11; tick(4);
    chk("R7 follow", {20'd0, mfrac}, 32'h456);
    chk("R6 par frac", {31'd0, frac_en}, 32'd1);
    s_load = 1'b1; tick(4);
    p_mint = 6'h33; p_mfrac = 12'h789; tick(4);
    chk("R7 held", {26'd0, mint}, 32'h22);
    chk("R7 no sr copy", {20'd0, mfrac}, 32'h456);
    sbit(1'b1); s_clk = 1'b0; tick(4);
    s_load = 1'b0; tick(4);
    chk("R7 reopen", {26'd0, mint}, 32'h33);
    par_mode = 1'b0; tick(4);
    chk("R1 no par shift", {31'd0, test_out}, 32'd1);

    // R9: shift and load in the same cycle
    w9 = {2'b01, 2'b10, 3'd6, 3'd5, 6'h15, 12'h3C7};
    sword(w9);
    s_data = 1'b1; tick(4);
    s_clk = 1'b1; s_load = 1'b1; tick(4);
    chk_cfg("R9 pre-shift", w9);
    chk("R9 shifted", {31'd0, test_out}, {31'd0, w9[26]});
    s_clk = 1'b0; s_load = 1'b0; tick(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule